// File: doc/BRIEF.md
# Custom Preamble Transmit Inserter

This block sits at the head of an Ethernet transmit path and supplies the bytes that go out ahead of a frame's destination address. Frame bytes arrive as a byte stream with start and end markers under a valid/ready handshake. For each frame, the block either generates the standard lead-in itself, or it forwards eight leading bytes that the frame carries as a user-defined lead-in. In both cases the rest of the frame then passes through unchanged.

A frame uses its own lead-in only when a global enable is set and the frame's start byte carries a per-frame flag. A mode input that selects reduced-pin (RMII) operation overrides this choice. In that mode the standard lead-in is always sent, and the eight leading bytes of a flagged frame are consumed and thrown away so that they never appear as frame data. Users are expected to place their custom content from the third lead-in byte onward, because a downstream code-group encoder may lose the first two.

The controller has five states:
- `ST_IDLE` waits for a start byte and chooses a path. The path is `ST_CUST` when enable and flag are set and RMII is off; `ST_DROP` when enable and flag are set and RMII is on; `ST_STD` in every other case.
- `ST_DROP` swallows eight input bytes and then moves to `ST_STD`, or back to `ST_IDLE` if the frame ends early.
- `ST_STD` emits the eight generated bytes and then moves to `ST_BODY`.
- `ST_CUST` forwards eight input bytes and then moves to `ST_BODY`, or back to `ST_IDLE` on an early end.
- `ST_BODY` passes bytes through and returns to `ST_IDLE` after the end byte.

Top module: `txpre_inserter`

## Requirements
- R1: While reset is asserted, and in idle with no frame offered, `m_valid` and `s_ready` are both 0.
- R2: The standard lead-in is seven bytes of 0x55 followed by 0xD5. `m_sop` is high on the first of these bytes only, and `s_ready` stays 0 while they are sent.
- R3: After the lead-in, every frame byte is forwarded unchanged and in order. `m_eop` is high on the frame's last byte only. When the input is continuous and `m_ready` stays high, no idle cycle appears between the first and last output byte.
- R4: With `cust_en`=1, `s_pre_flag`=1 and `rmii_mode`=0, the first eight input bytes are sent as the lead-in exactly as received, with `m_sop` on the first. The remaining bytes follow as frame data.
- R5: With `cust_en`=0, `s_pre_flag` has no effect. The standard lead-in is sent and every input byte, including the first eight, is forwarded as frame data.
- R6: With `cust_en`=1 and `s_pre_flag`=0, the standard lead-in is sent and every input byte is forwarded.
- R7: With `rmii_mode`=1, the standard lead-in is always sent. For a frame with `cust_en`=1 and `s_pre_flag`=1, the first eight input bytes are accepted and never appear on the output.
- R8: While `m_valid`=1 and `m_ready`=0, `m_valid` and `m_data` hold their values into the next cycle, and no byte is lost or duplicated.
- R9: If the input end marker arrives within the first eight bytes of a custom-lead-in frame, the bytes received so far are forwarded with `m_eop` on the last one. For a discarded (RMII) lead-in, no output is produced. A following frame is handled normally in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cust_en | input | 1 | Global enable for per-frame custom lead-in |
| rmii_mode | input | 1 | Reduced-pin mode; forces the standard lead-in |
| s_data | input | 8 | Input frame byte |
| s_valid | input | 1 | Input byte valid |
| s_sop | input | 1 | Input byte is the first of a frame |
| s_eop | input | 1 | Input byte is the last of a frame |
| s_pre_flag | input | 1 | Frame carries its own lead-in; sampled with the start byte |
| s_ready | output | 1 | Block accepts the input byte |
| m_data | output | 8 | Output byte |
| m_valid | output | 1 | Output byte valid |
| m_sop | output | 1 | Output byte is the first lead-in byte |
| m_eop | output | 1 | Output byte is the last frame byte |
| m_ready | input | 1 | Downstream accepts the output byte |

## Verification
The assertions check several properties on every cycle:
- the idle state offers and accepts nothing;
- the discard state never drives the output;
- the input is stalled while generated bytes go out;
- a stalled generated byte holds its value;
- no output follows an accepted end byte in the next cycle;
- an RMII start byte is always 0x55.

Only the bench scenarios can show which bytes appear, in what order, and with which markers, and that depends on the combination of enable, flag and mode. Those scenarios also cover the gap-free timing of a continuous frame, recovery after short frames, and the absence of discarded bytes.

// File: rtl/txpre_pkg.sv
package txpre_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DROP,
        ST_STD,
        ST_CUST,
        ST_BODY
    } state_t;

    localparam logic [7:0] LEAD_BYTE  = 8'h55;
    localparam logic [7:0] DELIM_BYTE = 8'hD5;

endpackage

// File: rtl/txpre_cnt.sv
module txpre_cnt #(
    parameter int LIMIT = 8,
    parameter int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] idx,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idx  = cnt_q;
    assign last = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/txpre_stdgen.sv
module txpre_stdgen #(
    parameter int LIMIT = 8,
    parameter int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic [CW-1:0] idx,
    output logic [7:0]    gen_byte,
    output logic          gen_first
);

    import txpre_pkg::*;

    always_comb begin
        gen_first = (idx == '0);
        if (idx == CW'(LIMIT - 1)) begin
            gen_byte = DELIM_BYTE;
        end else begin
            gen_byte = LEAD_BYTE;
        end
    end

endmodule

// File: rtl/txpre_fsm.sv
module txpre_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_valid,
    input  logic                s_sop,
    input  logic                s_eop,
    input  logic                s_pre_flag,
    input  logic                cust_en,
    input  logic                rmii_mode,
    input  logic                step,
    input  logic                last,
    output txpre_pkg::state_t   state
);

    import txpre_pkg::*;

    state_t state_q, state_d;
    logic   want_cust;

    assign want_cust = cust_en && s_pre_flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (s_valid && s_sop) begin
                    if (want_cust && !rmii_mode) begin
                        state_d = ST_CUST;
                    end else if (want_cust) begin
                        state_d = ST_DROP;
                    end else begin
                        state_d = ST_STD;
                    end
                end
            end
            ST_DROP: begin
                if (step && s_eop) begin
                    state_d = ST_IDLE;
                end else if (step && last) begin
                    state_d = ST_STD;
                end
            end
            ST_STD: begin
                if (step && last) begin
                    state_d = ST_BODY;
                end
            end
            ST_CUST: begin
                if (step && s_eop) begin
                    state_d = ST_IDLE;
                end else if (step && last) begin
                    state_d = ST_BODY;
                end
            end
            ST_BODY: begin
                if (step && s_eop) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/txpre_inserter.sv
module txpre_inserter #(
    parameter int PRE_LEN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cust_en,
    input  logic       rmii_mode,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_sop,
    input  logic       s_eop,
    input  logic       s_pre_flag,
    output logic       s_ready,
    output logic [7:0] m_data,
    output logic       m_valid,
    output logic       m_sop,
    output logic       m_eop,
    input  logic       m_ready
);

    import txpre_pkg::*;

    localparam int CW = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;

    state_t        fsm_state;
    logic [CW-1:0] pre_idx;
    logic          pre_last;
    logic          step;
    logic          cnt_inc;
    logic          cnt_clr;
    logic [7:0]    gen_byte;
    logic          gen_first;

    txpre_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_valid    (s_valid),
        .s_sop      (s_sop),
        .s_eop      (s_eop),
        .s_pre_flag (s_pre_flag),
        .cust_en    (cust_en),
        .rmii_mode  (rmii_mode),
        .step       (step),
        .last       (pre_last),
        .state      (fsm_state)
    );

    txpre_cnt #(.LIMIT(PRE_LEN), .CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .clr   (cnt_clr),
        .idx   (pre_idx),
        .last  (pre_last)
    );

    txpre_stdgen #(.LIMIT(PRE_LEN), .CW(CW)) u_gen (
        .idx       (pre_idx),
        .gen_byte  (gen_byte),
        .gen_first (gen_first)
    );

    always_comb begin
        s_ready = 1'b0;
        m_valid = 1'b0;
        m_data  = 8'h00;
        m_sop   = 1'b0;
        m_eop   = 1'b0;
        step    = 1'b0;
        cnt_inc = 1'b0;
        cnt_clr = 1'b0;
        unique case (fsm_state)
            ST_IDLE: begin
            end
            ST_DROP: begin
                s_ready = 1'b1;
                step    = s_valid;
                cnt_inc = step;
                cnt_clr = step && (pre_last || s_eop);
            end
            ST_STD: begin
                m_valid = 1'b1;
                m_data  = gen_byte;
                m_sop   = gen_first;
                step    = m_ready;
                cnt_inc = step;
                cnt_clr = step && pre_last;
            end
            ST_CUST: begin
                s_ready = m_ready;
                m_valid = s_valid;
                m_data  = s_data;
                m_sop   = gen_first;
                m_eop   = s_eop;
                step    = s_valid && m_ready;
                cnt_inc = step;
                cnt_clr = step && (pre_last || s_eop);
            end
            ST_BODY: begin
                s_ready = m_ready;
                m_valid = s_valid;
                m_data  = s_data;
                m_eop   = s_eop;
                step    = s_valid && m_ready;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/txpre_chk.sv
module txpre_chk (
    input logic              clk,
    input logic              rst_n,
    input txpre_pkg::state_t fsm_state,
    input logic              rmii_mode,
    input logic              s_ready,
    input logic [7:0]        m_data,
    input logic              m_valid,
    input logic              m_sop,
    input logic              m_eop,
    input logic              m_ready
);

    import txpre_pkg::*;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> (!m_valid && !s_ready));

    // R2
    std_stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_STD) |-> (m_valid && !s_ready));

    // R8
    std_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_STD && m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R3
    eop_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_eop) |=> !m_valid);

    // R7
    drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DROP) |-> !m_valid);

    // R7
    rmii_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_sop && rmii_mode) |-> (m_data == LEAD_BYTE));

endmodule

bind txpre_inserter txpre_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsm_state (fsm_state),
    .rmii_mode (rmii_mode),
    .s_ready   (s_ready),
    .m_data    (m_data),
    .m_valid   (m_valid),
    .m_sop     (m_sop),
    .m_eop     (m_eop),
    .m_ready   (m_ready)
);

// File: tb/txpre_inserter_tb.sv
`timescale 1ns/1ps
module txpre_inserter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cust_en = 1'b0;
    logic       rmii_mode = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_valid = 1'b0;
    logic       s_sop = 1'b0;
    logic       s_eop = 1'b0;
    logic       s_pre_flag = 1'b0;
    logic       s_ready;
    logic [7:0] m_data;
    logic       m_valid;
    logic       m_sop;
    logic       m_eop;
    logic       m_ready = 1'b1;

    int checks = 0;
    int errors = 0;

    logic [7:0] fr [0:79];
    logic [7:0] exq [$];
    logic [7:0] gq [$];
    bit         gsop [$];
    bit         geop [$];

    always #4 clk = ~clk;

    txpre_inserter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cust_en    (cust_en),
        .rmii_mode  (rmii_mode),
        .s_data     (s_data),
        .s_valid    (s_valid),
        .s_sop      (s_sop),
        .s_eop      (s_eop),
        .s_pre_flag (s_pre_flag),
        .s_ready    (s_ready),
        .m_data     (m_data),
        .m_valid    (m_valid),
        .m_sop      (m_sop),
        .m_eop      (m_eop),
        .m_ready    (m_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill(input int len, input int seed);
        for (int i = 0; i < 80; i++) begin
            fr[i] = (i < len) ? 8'((seed + i * 13) & 255) : 8'h00;
        end
    endtask

    task automatic push_std();
        for (int i = 0; i < 7; i++) exq.push_back(8'h55);
        exq.push_back(8'hD5);
    endtask

    task automatic run_frame(input string req, input int len, input bit flag,
                             input bit en, input bit rmii, input bit stall);
        int  idx = 0;
        int  cyc = 0;
        int  first = -1;
        int  lastc = -1;
        int  settle = 0;
        bit  prev_stall = 0;
        logic [7:0] prev_data = 8'h00;
        bit  stall_bad = 0;
        bit  data_bad = 0;
        int  bad_at = 0;
        bit  sop_bad = 0;
        bit  eop_bad = 0;
        exq.delete(); gq.delete(); gsop.delete(); geop.delete();
        if (en && flag && !rmii) begin
            for (int i = 0; i < len; i++) exq.push_back(fr[i]);
        end else if (en && flag && rmii) begin
            if (len > 8) begin
                push_std();
                for (int i = 8; i < len; i++) exq.push_back(fr[i]);
            end
        end else begin
            push_std();
            for (int i = 0; i < len; i++) exq.push_back(fr[i]);
        end
        @(negedge clk);
        cust_en   = en;
        rmii_mode = rmii;
        while (settle < 4 && cyc < 3000) begin
            @(negedge clk);
            s_valid    = (idx < len);
            s_data     = (idx < len) ? fr[idx] : 8'h00;
            s_sop      = (idx == 0);
            s_eop      = (idx == len - 1);
            s_pre_flag = flag;
            m_ready    = stall ? ((cyc % 3) != 2) : 1'b1;
            #1;
            if (prev_stall && (!m_valid || m_data != prev_data)) stall_bad = 1;
            prev_stall = m_valid && !m_ready;
            prev_data  = m_data;
            if (m_valid && m_ready) begin
                gq.push_back(m_data);
                gsop.push_back(m_sop);
                geop.push_back(m_eop);
                if (first < 0) first = cyc;
                lastc = cyc;
            end
            if (s_valid && s_ready) idx++;
            if (idx >= len) settle++;
            cyc++;
        end
        @(negedge clk);
        s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0; s_pre_flag = 1'b0; m_ready = 1'b1;
        check(cyc < 3000, req, "frame finished within cycle limit", cyc, 3000);
        check(gq.size() == exq.size(), req, "output byte count", gq.size(), exq.size());
        for (int i = 0; i < gq.size() && i < exq.size(); i++) begin
            if (!data_bad && gq[i] != exq[i]) begin
                data_bad = 1;
                bad_at = i;
            end
        end
        check(!data_bad, req, "output byte value",
              data_bad ? int'(gq[bad_at]) : 0, data_bad ? int'(exq[bad_at]) : 0);
        for (int i = 0; i < gq.size(); i++) begin
            if (gsop[i] != (i == 0)) sop_bad = 1;
            if (geop[i] != (i == gq.size() - 1)) eop_bad = 1;
        end
        check(!sop_bad, req, "start marker only on first output byte", sop_bad, 0);
        check(!eop_bad, req, "end marker only on last output byte", eop_bad, 0);
        if (!stall && gq.size() > 0) begin
            check(lastc - first + 1 == gq.size(), "R3", "gap-free output span",
                  lastc - first + 1, gq.size());
        end
        if (stall) begin
            check(!stall_bad, "R8", "output held while stalled", stall_bad, 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!m_valid && !s_ready, "R1", "quiet during reset", {m_valid, s_ready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!m_valid && !s_ready, "R1", "quiet in idle after reset", {m_valid, s_ready}, 0);
    endtask

    task automatic t_standard();
        fill(20, 3);
        run_frame("R2", 20, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_custom();
        fill(24, 7);
        fr[0] = 8'h55; fr[1] = 8'h55; fr[2] = 8'hA7; fr[3] = 8'h3C;
        fr[4] = 8'h55; fr[5] = 8'h55; fr[6] = 8'h55; fr[7] = 8'hD5;
        run_frame("R4", 24, 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_flag_no_enable();
        fill(20, 41);
        run_frame("R5", 20, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_enable_no_flag();
        fill(18, 90);
        run_frame("R6", 18, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_rmii_forced();
        fill(20, 17);
        run_frame("R7", 20, 1'b1, 1'b1, 1'b1, 1'b0);
        fill(12, 201);
        run_frame("R7", 12, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_backpressure();
        fill(22, 55);
        run_frame("R8", 22, 1'b1, 1'b1, 1'b0, 1'b1);
        fill(15, 120);
        run_frame("R8", 15, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_short();
        fill(5, 9);
        run_frame("R9", 5, 1'b1, 1'b1, 1'b0, 1'b0);
        fill(6, 77);
        run_frame("R9", 6, 1'b1, 1'b1, 1'b1, 1'b0);
        fill(10, 150);
        run_frame("R9", 10, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_standard();
        t_custom();
        t_flag_no_enable();
        t_enable_no_flag();
        t_rmii_forced();
        t_backpressure();
        t_short();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule